// File: doc/BRIEF.md
# Asynchronous Serial Port with Multiprocessor Address Filter

This block is a full-duplex asynchronous serial port. It is built to sit behind a small byte-wide register interface. Line timing comes from an external strobe, `baud_tick`, and sixteen strobes make one bit time. The port can send and receive short frames of 10 bits or long frames of 11 bits. A long frame carries a programmable ninth data bit between the data byte and the stop bit.

On the receive side the line is oversampled and each bit is decided by a three-sample majority vote. A start bit that does not hold is dropped. A stop bit that reads 0 raises a framing-error flag. In multiprocessor mode the receiver accepts a frame only when its ninth bit is 1 and its byte matches either the station address or the broadcast address. Bit positions that the mask clears are not compared. Only an accepted frame updates the receive registers and raises the receive flag. Rejected frames leave the registers untouched. In every case the receiver goes straight back to watching for the next falling edge.

Software reaches the block through one write port with a 2-bit select. The select codes are: 0 = control, 1 = transmit byte, 2 = station address, 3 = compare mask. Control bits: [0] long frame, [1] multiprocessor filter enable, [2] receiver enable, [3] transmit ninth bit, [4] transmit-done flag, [5] receive flag, [6] framing-error flag. A control write loads the three flags from bits [6:4], which is how software clears them. A hardware set in the same cycle takes priority.

Top module: `mp_uart`

## Requirements
- R1: After reset, `txd` is 1, the three flags `ti`, `ri` and `fe` are 0, and `rx_data` and `rx_bit9` are 0.
- R2: A write to select 1 while the transmitter is idle sends a short frame when control bit 0 is 0. The frame is a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. Each bit lasts 16 baud ticks, and `txd` rests at 1 between frames.
- R3: With control bit 0 set, the transmitter inserts control bit 3 as a ninth bit between data bit 7 and the stop bit, for 11 bits in all.
- R4: `ti` is set when the stop bit begins on `txd`. A write to select 1 while a frame is being sent changes nothing about that frame and starts no new one.
- R5: The receiver starts a frame on a 1-to-0 change of `rxd` seen at a baud tick. In a short frame it stores the byte in `rx_data` and the stop bit in `rx_bit9`. It sets `ri` in the middle of the stop bit: `ri` is still 0 a quarter of the way in and is 1 three quarters of the way in.
- R6: In a long frame the received ninth bit is stored in `rx_bit9`.
- R7: Each bit is decided by a majority vote over sub-bit samples 7, 8 and 9 of 16. A start bit that votes 1 is dropped as a false start with no flag set. A glitch that covers one sample does not change the bit.
- R8: A stop bit that votes 0 sets `fe`.
- R9: With control bit 1 set, a frame is accepted only if its ninth bit is 1 and `((byte ^ addr) & mask) == 0`. A rejected frame leaves `ri`, `rx_data` and `rx_bit9` unchanged.
- R10: In multiprocessor mode a frame whose ninth bit is 1 is also accepted when it matches the broadcast value `b = addr | mask`. A match means every bit that is 1 in `b` is 1 in the byte; the bits that are 0 in `b` are not compared.
- R11: With control bit 2 clear the receiver ignores `rxd`. After a stop bit the receiver accepts a new start bit at once, so frames sent back to back are each received.
- R12: A control write loads `ti`, `ri` and `fe` from data bits 4, 5 and 6, so writing 0 there clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial receive line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 transmit byte, 2 address, 3 mask |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 8 | Last accepted received byte |
| rx_bit9 | output | 1 | Ninth bit (long frame) or stop bit (short frame) of the last accepted frame |
| ti | output | 1 | Transmit flag, set at the start of the stop bit |
| ri | output | 1 | Receive flag, set mid stop bit for an accepted frame |
| fe | output | 1 | Framing-error flag |

## Verification
The assertions that tie a flag's rise to the end of a frame hold only when that rise does not come from a control write. The multiprocessor check holds only when the filter-enable bit stays unchanged across the cycle that completes the frame. The stimulus therefore writes control only while both lines are idle. `baud_tick` is a single-cycle pulse every fourth clock. Each serial bit is held for exactly 16 tick periods, so the sample points stay clear of the bit edges despite the two-stage synchronizer.

// File: rtl/mp_uart.sv
module mp_uart #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          ti,
  output logic          ri,
  output logic          fe
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 3);
  localparam logic [CW-1:0] S_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] S_V0   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_V1   = CW'(OSR / 2);
  localparam logic [CW-1:0] S_V2   = CW'(OSR / 2 + 1);
  localparam logic [BW-1:0] I_BYTE = BW'(DW);
  localparam logic [BW-1:0] I_SHRT = BW'(DW + 1);
  localparam logic [BW-1:0] I_LONG = BW'(DW + 2);

  logic          mode11, mp_en, rx_en, tx_b9;
  logic [DW-1:0] addr, mask;

  logic ctrl_wr, tx_wr;
  assign ctrl_wr = wr_en && (wr_sel == 2'd0);
  assign tx_wr   = wr_en && (wr_sel == 2'd1);

  // transmitter
  logic          tx_busy;
  logic [CW-1:0] tx_sub;
  logic [BW-1:0] tx_idx, tx_last;
  logic [DW+2:0] tx_sh;
  logic          ti_set;

  assign txd    = tx_sh[0];
  assign ti_set = tx_busy && baud_tick && (tx_sub == S_LAST) && (tx_idx + 1'b1 == tx_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sub  <= '0;
      tx_idx  <= '0;
      tx_last <= I_SHRT;
      tx_sh   <= '1;
    end else if (!tx_busy) begin
      if (tx_wr) begin
        tx_busy <= 1'b1;
        tx_sub  <= '0;
        tx_idx  <= '0;
        tx_last <= mode11 ? I_LONG : I_SHRT;
        tx_sh   <= {1'b1, mode11 ? tx_b9 : 1'b1, wr_data, 1'b0};
      end
    end else if (baud_tick) begin
      if (tx_sub == S_LAST) begin
        tx_sub <= '0;
        if (tx_idx == tx_last) tx_busy <= 1'b0;
        else begin
          tx_idx <= tx_idx + 1'b1;
          tx_sh  <= {1'b1, tx_sh[DW+2:1]};
        end
      end else tx_sub <= tx_sub + 1'b1;
    end

  // receiver
  logic [1:0]    rx_sync;
  logic          rx_s, rx_prev, rx_busy, rx_m11, rx_b9;
  logic [CW-1:0] rx_sub;
  logic [BW-1:0] rx_idx, stop_idx;
  logic [1:0]    rx_vote;
  logic [DW-1:0] rx_shift;
  logic          maj, rx_done, nine, addr_hit, bcast_hit, accept;
  logic [DW-1:0] bcast;

  assign rx_s      = rx_sync[1];
  assign stop_idx  = rx_m11 ? I_LONG : I_SHRT;
  assign maj       = (rx_vote[1] & rx_vote[0]) | (rx_vote[1] & rx_s) | (rx_vote[0] & rx_s);
  assign rx_done   = rx_busy && baud_tick && (rx_sub == S_V2) && (rx_idx == stop_idx);
  assign nine      = rx_m11 ? rx_b9 : maj;
  assign bcast     = addr | mask;
  assign addr_hit  = ((rx_shift ^ addr) & mask) == '0;
  assign bcast_hit = (rx_shift & bcast) == bcast;
  assign accept    = !mp_en || (nine && (addr_hit || bcast_hit));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_prev  <= 1'b1;
      rx_busy  <= 1'b0;
      rx_m11   <= 1'b0;
      rx_b9    <= 1'b0;
      rx_sub   <= '0;
      rx_idx   <= '0;
      rx_vote  <= '0;
      rx_shift <= '0;
    end else begin
      if (baud_tick) rx_prev <= rx_s;
      if (!rx_busy) begin
        if (baud_tick && rx_en && rx_prev && !rx_s) begin
          rx_busy <= 1'b1;
          rx_sub  <= CW'(1);
          rx_idx  <= '0;
          rx_m11  <= mode11;
        end
      end else if (baud_tick) begin
        if (rx_sub == S_V0 || rx_sub == S_V1) rx_vote <= {rx_vote[0], rx_s};
        if (rx_sub == S_V2) begin
          if (rx_idx == '0) begin
            if (maj) rx_busy <= 1'b0;
          end else if (rx_idx <= I_BYTE) rx_shift <= {maj, rx_shift[DW-1:1]};
          else if (rx_idx == stop_idx) rx_busy <= 1'b0;
          else rx_b9 <= maj;
        end
        if (rx_sub == S_LAST) begin
          rx_sub <= '0;
          rx_idx <= rx_idx + 1'b1;
        end else rx_sub <= rx_sub + 1'b1;
      end
    end

  // registers and flags
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {mode11, mp_en, rx_en, tx_b9} <= '0;
      addr    <= '0;
      mask    <= '0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      ti      <= 1'b0;
      ri      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      if (ctrl_wr) {tx_b9, rx_en, mp_en, mode11} <= wr_data[3:0];
      if (wr_en && wr_sel == 2'd2) addr <= wr_data;
      if (wr_en && wr_sel == 2'd3) mask <= wr_data;
      if (rx_done && accept) begin
        rx_data <= rx_shift;
        rx_bit9 <= nine;
      end
      ti <= ti_set || (ctrl_wr ? wr_data[4] : ti);
      ri <= (rx_done && accept) || (ctrl_wr ? wr_data[5] : ri);
      fe <= (rx_done && !maj) || (ctrl_wr ? wr_data[6] : fe);
    end

  assert_txd_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_ti_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti) && !$past(ctrl_wr)) |-> (tx_busy && tx_idx == tx_last && txd));

  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_wr && !(baud_tick && tx_sub == S_LAST)) |=> $stable(tx_sh));

  assert_ri_mid_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && !$past(ctrl_wr)) |-> ($past(rx_busy) && !rx_busy));

  assert_fe_end_of_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fe) && !$past(ctrl_wr)) |-> ($past(rx_busy) && !rx_busy));

  assert_mp_needs_ninth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && !$past(ctrl_wr) && mp_en && $past(mp_en)) |-> rx_bit9);
endmodule

// File: tb/test_mp_uart.sv
module test_mp_uart;
  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       txd, rx_bit9, ti, ri, fe;
  logic [7:0] rx_data;
  int nchk = 0, nerr = 0, tcnt = 0;

  mp_uart i_mp_uart (.clk, .rst_n, .baud_tick, .rxd, .wr_en, .wr_sel, .wr_data,
                     .txd, .rx_data, .rx_bit9, .ti, .ri, .fe);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    baud_tick = (tcnt == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [7:0] cval(input logic m11, mp, en, b9);
    return {4'b0, b9, en, mp, m11};
  endfunction

  task automatic drive_bit(input logic v);
    rxd = v; repeat (64) @(negedge clk);
  endtask

  task automatic send_body(input logic [7:0] d, input logic m11, input logic n9);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (m11) drive_bit(n9);
  endtask

  task automatic send_stop(input logic s);
    drive_bit(s); rxd = 1'b1; repeat (64) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 txd", txd, 1); check("R1 ti", ti, 0); check("R1 ri", ri, 0);
    check("R1 fe", fe, 0); check("R1 rx_data", rx_data, 0); check("R1 rx_bit9", rx_bit9, 0);
  endtask

  task automatic t_tx(input logic m11, input logic b9, input logic [7:0] d);
    logic [10:0] exp;
    int len;
    len = m11 ? 11 : 10;
    exp = m11 ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
    wr(2'd0, cval(m11, 0, 0, b9));
    wr(2'd1, d);
    for (int i = 0; i < len; i++) begin
      repeat (32) @(negedge clk);
      check(m11 ? "R3 tx bit" : "R2 tx bit", {24'd0, 4'(i), 3'd0, txd}, {24'd0, 4'(i), 3'd0, exp[i]});
      if (i == len - 2) check("R4 ti before stop", ti, 0);
      if (i == len - 1) check("R4 ti in stop", ti, 1);
      if (i == 3) begin
        wr(2'd1, 8'h00);
        repeat (31) @(negedge clk);
      end else repeat (32) @(negedge clk);
    end
    repeat (160) @(negedge clk);
    check("R4 no frame from busy write", txd, 1);
    wr(2'd0, cval(m11, 0, 0, b9));
    check("R12 ti cleared", ti, 0);
  endtask

  task automatic t_rx10;
    wr(2'd0, cval(0, 0, 1, 0));
    send_body(8'h3C, 1'b0, 1'b0);
    rxd = 1'b1; repeat (16) @(negedge clk);
    check("R5 ri not early", ri, 0);
    repeat (32) @(negedge clk);
    check("R5 ri mid stop", ri, 1);
    repeat (80) @(negedge clk);
    check("R5 rx_data", rx_data, 8'h3C);
    check("R5 stop into rx_bit9", rx_bit9, 1);
    check("R8 no fe on good stop", fe, 0);
    wr(2'd0, cval(0, 0, 1, 0));
    check("R12 ri cleared", ri, 0);
  endtask

  task automatic t_rx11;
    wr(2'd0, cval(1, 0, 1, 0));
    send_body(8'h81, 1'b1, 1'b0); send_stop(1'b1);
    check("R6 rx_data", rx_data, 8'h81);
    check("R6 ninth bit 0", rx_bit9, 0);
    check("R6 ri", ri, 1);
    wr(2'd0, cval(1, 0, 1, 0));
    send_body(8'h7E, 1'b1, 1'b1); send_stop(1'b1);
    check("R6 ninth bit 1", rx_bit9, 1);
    wr(2'd0, cval(0, 0, 1, 0));
  endtask

  task automatic t_votes;
    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (1000) @(negedge clk);
    check("R7 false start ri", ri, 0);
    check("R7 false start fe", fe, 0);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++)
      if (i == 1) begin
        rxd = 1'b1; repeat (30) @(negedge clk);
        rxd = 1'b0; repeat (4) @(negedge clk);
        rxd = 1'b1; repeat (30) @(negedge clk);
      end else drive_bit(8'h5A >> i);
    send_stop(1'b1);
    check("R7 glitch outvoted", rx_data, 8'h5A);
    wr(2'd0, cval(0, 0, 1, 0));
  endtask

  task automatic t_fe;
    send_body(8'h96, 1'b0, 1'b0); send_stop(1'b0);
    check("R8 fe set", fe, 1);
    check("R8 data kept", rx_data, 8'h96);
    check("R8 stop 0 in rx_bit9", rx_bit9, 0);
    wr(2'd0, cval(0, 0, 1, 0));
    check("R12 fe cleared", fe, 0);
  endtask

  task automatic t_mp;
    wr(2'd2, 8'hC0); wr(2'd3, 8'hFD);
    wr(2'd0, cval(1, 1, 1, 0));
    send_body(8'hC2, 1'b1, 1'b1); send_stop(1'b1);
    check("R9 masked address accepted ri", ri, 1);
    check("R9 masked address data", rx_data, 8'hC2);
    wr(2'd0, cval(1, 1, 1, 0));
    send_body(8'hC4, 1'b1, 1'b1); send_stop(1'b1);
    check("R9 mismatch ri", ri, 0);
    check("R9 mismatch data kept", rx_data, 8'hC2);
    send_body(8'hC0, 1'b1, 1'b0); send_stop(1'b1);
    check("R9 ninth 0 rejected", ri, 0);
    check("R9 ninth 0 data kept", rx_data, 8'hC2);
  endtask

  task automatic t_bcast;
    send_body(8'hFD, 1'b1, 1'b1); send_stop(1'b1);
    check("R10 broadcast ri", ri, 1);
    check("R10 broadcast data", rx_data, 8'hFD);
    wr(2'd0, cval(1, 1, 1, 0));
    send_body(8'hFF, 1'b1, 1'b1); send_stop(1'b1);
    check("R10 broadcast dont-care data", rx_data, 8'hFF);
    wr(2'd0, cval(0, 0, 1, 0));
  endtask

  task automatic t_rxen;
    wr(2'd0, cval(0, 0, 0, 0));
    send_body(8'h44, 1'b0, 1'b0); send_stop(1'b1);
    check("R11 disabled ri", ri, 0);
    check("R11 disabled data", rx_data, 8'hFF);
    wr(2'd0, cval(0, 0, 1, 0));
    send_body(8'h11, 1'b0, 1'b0); drive_bit(1'b1);
    check("R11 first of pair", rx_data, 8'h11);
    send_body(8'h22, 1'b0, 1'b0); send_stop(1'b1);
    check("R11 second of pair", rx_data, 8'h22);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_tx(1'b0, 1'b0, 8'hA5);
    t_tx(1'b1, 1'b1, 8'h3B);
    t_tx(1'b1, 1'b0, 8'hC6);
    t_rx10;
    t_rx11;
    t_votes;
    t_fe;
    t_mp;
    t_bcast;
    t_rxen;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule